// File: doc/BRIEF.md
# In-Band Software Flow Controller

This block sits between a byte-oriented serial transmitter/receiver pair and the user's data paths. It adds in-band software flow control. On the receive side it watches each incoming byte. A stop byte (0x13) halts the local transmit direction, and a go byte (0x11) resumes it. Both control bytes are absorbed and never reach the user. Reception itself is never halted.

On the transmit side it watches the fill level of the local receive buffer. When the level climbs to a high mark, a stop byte is sent to the peer. When the level drains to a low mark, a go byte is sent, but only if a stop byte went out before. Control bytes are given priority over user data. User bytes equal to a control value cannot be carried in-band, so they are dropped and flagged.

A lost go byte would stall the link forever. For that case, a programmable resume timeout releases the paused state on its own. All byte paths use valid/ready handshakes.

Top module: `xonxoff_flow_ctrl`

## Requirements
- R1: After reset, `tx_paused` is 0 and `txo_valid` is 0. While the fill level stays below the high mark, no byte is emitted (no go byte without an earlier stop byte).
- R2: A received byte 0x13, accepted by handshake, sets `tx_paused` from the next cycle. While paused, `utx_ready` is 0 and no user byte is emitted, but received data bytes are still forwarded on `urx_*`.
- R3: A received byte 0x11, accepted by handshake, clears `tx_paused` in the next cycle, and held user data then flows again.
- R4: Received bytes 0x11 and 0x13 are always accepted (`rx_ready`=1) and never appear on `urx_valid`. Every other byte is passed combinationally to `urx_*`, with `rx_ready` following `urx_ready`.
- R5: With `resume_cycles`=N (N>0), `tx_paused` stays high for exactly N cycles after a stop byte is received, then clears by itself. With N=0 it never times out.
- R6: When `fill_level` reaches `HI_MARK` or above, exactly one 0x13 byte is emitted on `txo_*`, however long the level stays high.
- R7: When `fill_level` later falls to `LO_MARK` or below, exactly one 0x11 byte is emitted. Levels between the two marks emit nothing.
- R8: A pending control byte is emitted before any waiting user byte. It is emitted even while the local transmitter is paused.
- R9: While `txo_valid` is 1 and `txo_ready` is 0, `txo_valid` and `txo_data` stay unchanged. A byte on offer is never replaced or withdrawn.
- R10: A user byte equal to 0x11 or 0x13 is accepted but never emitted. `ctrl_err` is 1 for exactly the cycle after that handshake.
- R11: A user byte accepted on `utx_*` is offered on `txo_*` from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | Received byte available from the serial receiver |
| rx_byte | input | 8 | Received byte value |
| rx_ready | output | 1 | Block accepts the received byte |
| urx_valid | output | 1 | Data byte offered to the user |
| urx_data | output | 8 | Data byte to the user |
| urx_ready | input | 1 | User accepts the data byte |
| utx_valid | input | 1 | User offers a byte to send |
| utx_data | input | 8 | User byte to send |
| utx_ready | output | 1 | Block accepts the user byte |
| txo_valid | output | 1 | Byte offered to the serial transmitter |
| txo_data | output | 8 | Byte to the serial transmitter |
| txo_ready | input | 1 | Serial transmitter accepts the byte |
| fill_level | input | LVL_W | Current fill level of the local receive buffer |
| resume_cycles | input | TMO_W | Pause timeout in cycles, 0 disables it |
| tx_paused | output | 1 | Local transmit direction halted by the peer |
| ctrl_err | output | 1 | One-cycle pulse: a user byte equal to a control value was dropped |

## Verification
A wrong pause state shows up at once as `tx_paused` and `utx_ready`, one cycle after the received control byte. A timeout counter that is off by one moves the falling edge of `tx_paused` by one cycle, so that edge is sampled exactly. A wrong outstanding-stop record in the fill watcher shows up only when the level falls to the low mark: a missing go byte, or a go byte that should not be there, appears on `txo_*` within two cycles. Ordering faults in the output stage show up as a wrong sequence of captured bytes when a stop byte competes with queued user data.

// File: rtl/xfc_pkg.sv
// Shared constants and helpers for the in-band flow controller.
// Assumes 8-bit bytes; control values are fixed by the protocol.
package xfc_pkg;
    localparam logic [7:0] XON_BYTE  = 8'h11;
    localparam logic [7:0] XOFF_BYTE = 8'h13;

    // True when a byte carries one of the two control values
    function automatic logic is_ctrl(input logic [7:0] b);
        return (b == XON_BYTE) || (b == XOFF_BYTE);
    endfunction
endpackage

// File: rtl/xfc_rx_filter.sv
// Receive filter: strips control bytes from the incoming stream and keeps
// the local transmitter's pause state, including the resume timeout.
// Assumes the serial receiver follows valid/ready and holds a byte until taken.
module xfc_rx_filter
    import xfc_pkg::*;
#(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_valid,
    input  logic [7:0]       rx_byte,
    output logic             rx_ready,
    output logic             urx_valid,
    output logic [7:0]       urx_data,
    input  logic             urx_ready,
    input  logic [TMO_W-1:0] resume_cycles,
    output logic             paused
);
    logic             byte_is_ctrl;
    logic             rx_take;
    logic [TMO_W-1:0] wait_cnt;

    // Classify the byte and steer it: control bytes are sunk here
    always_comb begin
        byte_is_ctrl = is_ctrl(rx_byte);
        urx_valid    = rx_valid && !byte_is_ctrl;
        urx_data     = rx_byte;
        rx_ready     = byte_is_ctrl || urx_ready;
        rx_take      = rx_valid && rx_ready;
    end

    // Pause state with timeout counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            paused   <= 1'b0;
            wait_cnt <= '0;
        end else if (rx_take && rx_byte == XOFF_BYTE) begin
            paused   <= 1'b1;
            wait_cnt <= '0;
        end else if (rx_take && rx_byte == XON_BYTE) begin
            paused   <= 1'b0;
            wait_cnt <= '0;
        end else if (paused && resume_cycles != '0) begin
            if (wait_cnt == resume_cycles - 1'b1) begin
                paused   <= 1'b0;
                wait_cnt <= '0;
            end else begin
                wait_cnt <= wait_cnt + 1'b1;
            end
        end
    end

    // R4
    no_ctrl_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        urx_valid |-> (urx_data != XON_BYTE && urx_data != XOFF_BYTE));
    // R2
    stop_sets_pause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_ready && rx_byte == XOFF_BYTE) |=> paused);
    // R3
    go_clears_pause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_ready && rx_byte == XON_BYTE) |=> !paused);
endmodule

// File: rtl/xfc_fill_watch.sv
// Fill watcher: applies hysteresis to the receive buffer level and raises
// requests for a stop or go byte. A go byte is requested only while a stop
// byte is outstanding. Assumes HI_MARK > LO_MARK.
module xfc_fill_watch #(
    parameter int LVL_W   = 8,
    parameter int HI_MARK = 12,
    parameter int LO_MARK = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] fill_level,
    input  logic             sent_off,
    input  logic             sent_on,
    output logic             pend_off,
    output logic             pend_on
);
    localparam logic [LVL_W-1:0] HI_LVL = LVL_W'(HI_MARK);
    localparam logic [LVL_W-1:0] LO_LVL = LVL_W'(LO_MARK);

    logic peer_held;    // the peer has been asked to stop
    logic off_in_air;   // a stop byte went out with no go byte since

    // Track whether a stop byte is outstanding at the peer
    always_ff @(posedge clk) begin
        if (!rst_n)        off_in_air <= 1'b0;
        else if (sent_off) off_in_air <= 1'b1;
        else if (sent_on)  off_in_air <= 1'b0;
    end

    // Hysteresis decision and pending control-byte requests
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            peer_held <= 1'b0;
            pend_off  <= 1'b0;
            pend_on   <= 1'b0;
        end else begin
            if (sent_off) pend_off <= 1'b0;
            if (sent_on)  pend_on  <= 1'b0;
            if (!peer_held && fill_level >= HI_LVL) begin
                peer_held <= 1'b1;
                pend_off  <= 1'b1;
                pend_on   <= 1'b0;
            end else if (peer_held && fill_level <= LO_LVL) begin
                peer_held <= 1'b0;
                pend_off  <= 1'b0;
                if (off_in_air || sent_off) pend_on <= 1'b1;
            end
        end
    end

    // R7
    go_needs_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend_on |-> off_in_air);
    // R8
    single_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(pend_on && pend_off));
endmodule

// File: rtl/xfc_tx_merge.sv
// Transmit merger: a one-byte output register fed by pending control bytes
// first and by user bytes second. User bytes are held back while paused,
// and user bytes equal to a control value are dropped and flagged.
// Assumes the serial transmitter follows valid/ready.
module xfc_tx_merge
    import xfc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       paused,
    input  logic       pend_off,
    input  logic       pend_on,
    input  logic       utx_valid,
    input  logic [7:0] utx_data,
    output logic       utx_ready,
    output logic       txo_valid,
    output logic [7:0] txo_data,
    input  logic       txo_ready,
    output logic       sent_off,
    output logic       sent_on,
    output logic       ctrl_err
);
    logic slot_free;
    logic user_take;
    logic user_bad;

    // Slot arbitration: control requests outrank user data
    always_comb begin
        slot_free = !txo_valid || txo_ready;
        sent_off  = slot_free && pend_off;
        sent_on   = slot_free && pend_on && !pend_off;
        utx_ready = slot_free && !pend_off && !pend_on && !paused;
        user_take = utx_valid && utx_ready;
        user_bad  = user_take && is_ctrl(utx_data);
    end

    // Output register load and error pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            txo_valid <= 1'b0;
            txo_data  <= '0;
            ctrl_err  <= 1'b0;
        end else begin
            ctrl_err <= user_bad;
            if (slot_free) begin
                if (sent_off) begin
                    txo_valid <= 1'b1;
                    txo_data  <= XOFF_BYTE;
                end else if (sent_on) begin
                    txo_valid <= 1'b1;
                    txo_data  <= XON_BYTE;
                end else if (user_take && !user_bad) begin
                    txo_valid <= 1'b1;
                    txo_data  <= utx_data;
                end else begin
                    txo_valid <= 1'b0;
                end
            end
        end
    end

    // R9
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (txo_valid && !txo_ready) |=> (txo_valid && $stable(txo_data)));
    // R10
    err_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_err |-> $past(utx_valid && utx_ready));
    // R2
    idle_when_paused_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (paused && slot_free && !pend_off && !pend_on) |=> !txo_valid);
endmodule

// File: rtl/xonxoff_flow_ctrl.sv
// Top of the in-band flow controller: wires the receive filter, the fill
// watcher and the transmit merger. Assumes HI_MARK > LO_MARK and that both
// marks fit in LVL_W bits.
module xonxoff_flow_ctrl #(
    parameter int LVL_W   = 8,
    parameter int HI_MARK = 12,
    parameter int LO_MARK = 4,
    parameter int TMO_W   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_valid,
    input  logic [7:0]       rx_byte,
    output logic             rx_ready,
    output logic             urx_valid,
    output logic [7:0]       urx_data,
    input  logic             urx_ready,
    input  logic             utx_valid,
    input  logic [7:0]       utx_data,
    output logic             utx_ready,
    output logic             txo_valid,
    output logic [7:0]       txo_data,
    input  logic             txo_ready,
    input  logic [LVL_W-1:0] fill_level,
    input  logic [TMO_W-1:0] resume_cycles,
    output logic             tx_paused,
    output logic             ctrl_err
);
    logic pend_off, pend_on, sent_off, sent_on;

    xfc_rx_filter #(.TMO_W(TMO_W)) u_rx (
        .clk(clk), .rst_n(rst_n),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_ready(rx_ready),
        .urx_valid(urx_valid), .urx_data(urx_data), .urx_ready(urx_ready),
        .resume_cycles(resume_cycles), .paused(tx_paused)
    );

    xfc_fill_watch #(.LVL_W(LVL_W), .HI_MARK(HI_MARK), .LO_MARK(LO_MARK)) u_fill (
        .clk(clk), .rst_n(rst_n), .fill_level(fill_level),
        .sent_off(sent_off), .sent_on(sent_on),
        .pend_off(pend_off), .pend_on(pend_on)
    );

    xfc_tx_merge u_tx (
        .clk(clk), .rst_n(rst_n), .paused(tx_paused),
        .pend_off(pend_off), .pend_on(pend_on),
        .utx_valid(utx_valid), .utx_data(utx_data), .utx_ready(utx_ready),
        .txo_valid(txo_valid), .txo_data(txo_data), .txo_ready(txo_ready),
        .sent_off(sent_off), .sent_on(sent_on), .ctrl_err(ctrl_err)
    );

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        $past(!rst_n) |-> (!tx_paused && !txo_valid));
endmodule

// File: tb/xonxoff_flow_ctrl_test.sv
module xonxoff_flow_ctrl_test;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        rx_ready;
    logic        urx_valid;
    logic [7:0]  urx_data;
    logic        urx_ready = 1'b1;
    logic        utx_valid = 1'b0;
    logic [7:0]  utx_data = '0;
    logic        utx_ready;
    logic        txo_valid;
    logic [7:0]  txo_data;
    logic        txo_ready = 1'b1;
    logic [7:0]  fill_level = '0;
    logic [15:0] resume_cycles = '0;
    logic        tx_paused;
    logic        ctrl_err;

    int total = 0;
    int bad = 0;
    logic [7:0] cap [0:255];
    int ncap = 0;

    always #(PERIOD/2) clk = ~clk;

    xonxoff_flow_ctrl uut (
        .clk(clk), .rst_n(rst_n),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_ready(rx_ready),
        .urx_valid(urx_valid), .urx_data(urx_data), .urx_ready(urx_ready),
        .utx_valid(utx_valid), .utx_data(utx_data), .utx_ready(utx_ready),
        .txo_valid(txo_valid), .txo_data(txo_data), .txo_ready(txo_ready),
        .fill_level(fill_level), .resume_cycles(resume_cycles),
        .tx_paused(tx_paused), .ctrl_err(ctrl_err)
    );

    // Record every byte handed to the serial transmitter
    always @(posedge clk) begin
        if (rst_n && txo_valid && txo_ready && ncap < 256) begin
            cap[ncap] <= txo_data;
            ncap      <= ncap + 1;
        end
    end

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic push_user(input logic [7:0] b);
        utx_data  = b;
        utx_valid = 1'b1;
        #1;
        while (!utx_ready) begin @(negedge clk); #1; end
        @(posedge clk);
        @(negedge clk);
        utx_valid = 1'b0;
    endtask

    task automatic feed_rx(input logic [7:0] b);
        rx_byte  = b;
        rx_valid = 1'b1;
        #1;
        while (!rx_ready) begin @(negedge clk); #1; end
        @(posedge clk);
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic t_reset;
        chk(tx_paused == 1'b0, "R1 paused after reset", tx_paused, 0);
        chk(txo_valid == 1'b0, "R1 txo_valid after reset", txo_valid, 0);
        idle(5);
        chk(ncap == 0, "R1 no go byte without stop", ncap, 0);
    endtask

    task automatic t_rx_path;
        urx_ready = 1'b0;
        rx_byte   = 8'h41;
        rx_valid  = 1'b1;
        #1;
        chk(urx_valid && urx_data == 8'h41, "R4 data forwarded", urx_data, 8'h41);
        chk(rx_ready == 1'b0, "R4 ready follows user", rx_ready, 0);
        rx_byte = 8'h13;
        #1;
        chk(urx_valid == 1'b0, "R4 stop byte stripped", urx_valid, 0);
        chk(rx_ready == 1'b1, "R4 stop byte accepted", rx_ready, 1);
        rx_byte = 8'h11;
        #1;
        chk(urx_valid == 1'b0 && rx_ready, "R4 go byte stripped", urx_valid, 0);
        rx_valid  = 1'b0;
        urx_ready = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_pause_resume;
        int base;
        base = ncap;
        feed_rx(8'h13);
        chk(tx_paused == 1'b1, "R2 paused after stop byte", tx_paused, 1);
        rx_byte  = 8'h55;
        rx_valid = 1'b1;
        #1;
        chk(urx_valid && urx_data == 8'h55, "R2 reception continues", urx_data, 8'h55);
        rx_valid  = 1'b0;
        utx_data  = 8'h22;
        utx_valid = 1'b1;
        #1;
        chk(utx_ready == 1'b0, "R2 user blocked while paused", utx_ready, 0);
        idle(3);
        chk(ncap == base, "R2 nothing emitted while paused", ncap, base);
        utx_valid = 1'b0;
        feed_rx(8'h11);
        chk(tx_paused == 1'b0, "R3 resumed after go byte", tx_paused, 0);
        push_user(8'h22);
        idle(2);
        chk(ncap == base + 1 && cap[base] == 8'h22, "R3 user data flows again",
            cap[base], 8'h22);
    endtask

    task automatic t_timeout;
        resume_cycles = 16'd5;
        feed_rx(8'h13);
        for (int i = 0; i < 5; i++) begin
            chk(tx_paused == 1'b1, "R5 paused within timeout", tx_paused, 1);
            @(negedge clk);
        end
        chk(tx_paused == 1'b0, "R5 released after timeout", tx_paused, 0);
        resume_cycles = 16'd0;
        feed_rx(8'h13);
        idle(20);
        chk(tx_paused == 1'b1, "R5 zero disables timeout", tx_paused, 1);
        feed_rx(8'h11);
    endtask

    task automatic t_fill;
        int base;
        base = ncap;
        fill_level = 8'd12;
        idle(4);
        chk(ncap == base + 1 && cap[base] == 8'h13, "R6 stop byte at high mark",
            cap[base], 8'h13);
        idle(6);
        chk(ncap == base + 1, "R6 only one stop byte", ncap, base + 1);
        fill_level = 8'd8;
        idle(4);
        chk(ncap == base + 1, "R7 nothing between marks", ncap, base + 1);
        fill_level = 8'd4;
        idle(4);
        chk(ncap == base + 2 && cap[base+1] == 8'h11, "R7 go byte at low mark",
            cap[base+1], 8'h11);
        idle(4);
        chk(ncap == base + 2, "R7 only one go byte", ncap, base + 2);
        fill_level = 8'd0;
    endtask

    task automatic t_priority;
        int base;
        base = ncap;
        txo_ready = 1'b0;
        push_user(8'h30);
        chk(txo_valid && txo_data == 8'h30, "R11 byte offered next cycle", txo_data, 8'h30);
        fill_level = 8'd20;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(txo_valid && txo_data == 8'h30, "R9 stalled byte held", txo_data, 8'h30);
        end
        fork
            push_user(8'h31);
            txo_ready = 1'b1;
        join
        idle(3);
        chk(ncap == base + 3, "R8 three bytes out", ncap, base + 3);
        chk(cap[base] == 8'h30, "R9 stalled byte not cut", cap[base], 8'h30);
        chk(cap[base+1] == 8'h13, "R8 stop byte ahead of user", cap[base+1], 8'h13);
        chk(cap[base+2] == 8'h31, "R8 user byte after stop", cap[base+2], 8'h31);
        fill_level = 8'd0;
        idle(4);
        chk(ncap == base + 4 && cap[base+3] == 8'h11, "R7 go byte after drain",
            cap[base+3], 8'h11);
    endtask

    task automatic t_ctrl_while_paused;
        int base;
        base = ncap;
        feed_rx(8'h13);
        fill_level = 8'd12;
        idle(4);
        chk(ncap == base + 1 && cap[base] == 8'h13, "R8 stop byte sent while paused",
            cap[base], 8'h13);
        chk(tx_paused == 1'b1, "R2 still paused", tx_paused, 1);
        fill_level = 8'd0;
        idle(4);
        chk(ncap == base + 2 && cap[base+1] == 8'h11, "R8 go byte sent while paused",
            cap[base+1], 8'h11);
        feed_rx(8'h11);
        chk(tx_paused == 1'b0, "R3 resumed", tx_paused, 0);
    endtask

    task automatic t_user_ctrl;
        int base;
        base = ncap;
        push_user(8'h11);
        chk(ctrl_err == 1'b1, "R10 error on user go value", ctrl_err, 1);
        @(negedge clk);
        chk(ctrl_err == 1'b0, "R10 error is one cycle", ctrl_err, 0);
        push_user(8'h13);
        chk(ctrl_err == 1'b1, "R10 error on user stop value", ctrl_err, 1);
        idle(3);
        chk(ncap == base, "R10 control-valued user bytes dropped", ncap, base);
        push_user(8'h5A);
        chk(txo_valid && txo_data == 8'h5A && !ctrl_err, "R11 normal byte offered",
            txo_data, 8'h5A);
        idle(2);
    endtask

    initial begin
        #(PERIOD * 100000);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=0x0 expected=0x1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        t_reset;
        t_rx_path;
        t_pause_resume;
        t_timeout;
        t_fill;
        t_priority;
        t_ctrl_while_paused;
        t_user_ctrl;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule